// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM Core

This block models a small pipelined synchronous static RAM with a shared data bus, which is presented here as a separate input word, output word and output-drive enable. Every control, address and write-data input is captured on the rising clock edge. Read data passes through one output register, so a read started at one edge appears on the bus after the following edge. Two address strobes start accesses: a processor-side strobe that is only honoured while the first chip select is active, and a controller-side strobe. Three chip selects, one active high and two active low, qualify both strobes. A two-bit wrapping burst counter then steps the low address bits in either linear or interleaved order.

Writes are either full-word (all-bytes write) or per-byte (byte-write enable with one select per byte). A write started by the controller strobe finishes at the same edge. A write started by the processor strobe finishes one edge later, because the write inputs are not looked at on the edge that loads the address. The output-drive enable is held off in three cases: while output enable is inactive, in the cycle after any write edge, and in the cycle after an edge that selects or deselects the device.

Top module: `psram_core`

## Requirements
- R1: A read starts at an edge where a strobe is accepted with all three chip selects active, and `wr_all_n` and `wr_byte_n` are both high. The addressed word is on `dq_o`, with `dq_oe` high if `out_en_n` is low, after the next rising edge.
- R2: Reads started on consecutive edges deliver one word per cycle, in issue order.
- R3: `proc_strb_n` is ignored while `sel_a_n` is high. If `ctrl_strb_n` is also high, that edge behaves as a plain continuation cycle and no new address is loaded.
- R4: After an edge that selects the device from the deselected state, `dq_oe` stays low for that cycle.
- R5: An edge with an accepted strobe and any chip select inactive deselects the device. `dq_oe` is low right after that edge, even if a read had been started one edge earlier.
- R6: A processor-strobe access ignores the write inputs and `burst_adv_n` on its loading edge. With both strobes high at the next edge, active write inputs write `dq_i` to the loaded address (`burst_adv_n` high).
- R7: A controller-strobe edge with `proc_strb_n` not accepted, all selects active and write inputs active writes `dq_i` to `addr_in` at that edge. A read issued at the next edge returns the new word.
- R8: `wr_all_n` low writes all four bytes, whatever `wr_byte_n` and `byte_sel_n` hold.
- R9: With `wr_all_n` high and `wr_byte_n` low, byte i (bits 8i+7:8i) is written exactly when `byte_sel_n[i]` is low. Unselected bytes keep their contents.
- R10: After any edge that performs a write, `dq_oe` is low for that cycle, even if `out_en_n` is low.
- R11: `out_en_n` high forces `dq_oe` low without waiting for a clock edge.
- R12: With `seq_linear` high when the address is loaded, each continuation edge with `burst_adv_n` low sets the low two address bits to base+1, +2, +3 modulo 4. The upper bits stay fixed.
- R13: With `seq_linear` low when the address is loaded, the low two bits on the k-th advance are base XOR k.
- R14: A continuation edge with `burst_adv_n` high accesses the same address again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_in | input | AW | Word address |
| proc_strb_n | input | 1 | Processor-side address strobe, active low, gated by `sel_a_n` |
| ctrl_strb_n | input | 1 | Controller-side address strobe, active low |
| burst_adv_n | input | 1 | Advance burst counter on a continuation edge, active low |
| sel_a_n | input | 1 | Chip select A, active low |
| sel_b | input | 1 | Chip select B, active high |
| sel_c_n | input | 1 | Chip select C, active low |
| wr_all_n | input | 1 | Write all bytes, active low |
| wr_byte_n | input | 1 | Byte-write enable, active low |
| byte_sel_n | input | NB | Per-byte write selects, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| seq_linear | input | 1 | Burst order taken at address load: 1 linear, 0 interleaved |
| dq_i | input | NB*8 | Write data from the bus |
| dq_o | output | NB*8 | Registered read data |
| dq_oe | output | 1 | Bus drive enable |

## Verification
On every cycle, the checker verifies the output-drive rules: the gating by output enable, the quiet cycle after a write edge, after a deselecting edge and after a reselecting edge. It also verifies that the processor strobe loads nothing while its chip select is off, and that it never writes on its loading edge. Data behaviour needs the bench's directed scenarios: the one-cycle read latency, back-to-back ordering, byte merging, the override by the all-bytes write, the two write latencies, and both burst orders including wrap-around and suspend. These are compared against a reference array kept in the bench.

// File: rtl/psram_pkg.sv
package psram_pkg;
  // kind of array access decided at a clock edge
  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2,
    ACC_DESEL = 2'd3
  } acc_e;
endpackage

// File: rtl/psram_burst.sv
module psram_burst #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic          lin_in,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] cur_addr,
  output logic [AW-1:0] nxt_addr
);
  logic [AW-1:0] base_q, base_d;
  logic [1:0]    cnt_q, cnt_d;
  logic          lin_q, lin_d;
  logic [1:0]    cnt_inc;

  function automatic logic [1:0] low_bits(input logic lin, input logic [1:0] b,
                                          input logic [1:0] c);
    return lin ? (b + c) : (b ^ c);
  endfunction

  assign cnt_inc  = cnt_q + 2'd1;
  assign cur_addr = {base_q[AW-1:2], low_bits(lin_q, base_q[1:0], cnt_q)};
  assign nxt_addr = {base_q[AW-1:2], low_bits(lin_q, base_q[1:0], cnt_inc)};

  always_comb begin
    base_d = base_q;
    cnt_d  = cnt_q;
    lin_d  = lin_q;
    if (load) begin
      base_d = addr_in;
      cnt_d  = 2'd0;
      lin_d  = lin_in;
    end else if (step) begin
      cnt_d  = cnt_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
      lin_q  <= 1'b0;
    end else begin
      base_q <= base_d;
      cnt_q  <= cnt_d;
      lin_q  <= lin_d;
    end
  end
endmodule

// File: rtl/psram_ctrl.sv
module psram_ctrl #(
  parameter int NB = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             proc_strb_n,
  input  logic             ctrl_strb_n,
  input  logic             burst_adv_n,
  input  logic             sel_a_n,
  input  logic             sel_b,
  input  logic             sel_c_n,
  input  logic             wr_all_n,
  input  logic             wr_byte_n,
  input  logic [NB-1:0]    byte_sel_n,
  output psram_pkg::acc_e  acc,
  output logic             load,
  output logic             step,
  output logic [NB-1:0]    wmask,
  output logic             sel_q
);
  import psram_pkg::*;

  logic          p_go, c_go, strobe, cs_all, wr_req, sel_d;
  logic [NB-1:0] req_mask;

  // processor strobe only counts while select A is active; it wins over the other
  assign p_go   = !proc_strb_n && !sel_a_n;
  assign c_go   = !ctrl_strb_n && !p_go;
  assign strobe = p_go || c_go;
  assign cs_all = !sel_a_n && sel_b && !sel_c_n;
  assign wr_req = !wr_all_n || !wr_byte_n;

  always_comb begin
    if (!wr_all_n)       req_mask = '1;
    else if (!wr_byte_n) req_mask = ~byte_sel_n;
    else                 req_mask = '0;
  end

  always_comb begin
    acc   = ACC_NONE;
    load  = 1'b0;
    step  = 1'b0;
    sel_d = sel_q;
    if (strobe) begin
      sel_d = cs_all;
      if (!cs_all) begin
        acc = ACC_DESEL;
      end else begin
        load = 1'b1;
        acc  = (c_go && wr_req) ? ACC_WRITE : ACC_READ;
      end
    end else if (sel_q) begin
      step = !burst_adv_n;
      acc  = wr_req ? ACC_WRITE : ACC_READ;
    end
  end

  assign wmask = (acc == ACC_WRITE) ? req_mask : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= 1'b0;
    else        sel_q <= sel_d;
  end
endmodule

// File: rtl/psram_array.sv
module psram_array #(
  parameter int AW = 6,
  parameter int NB = 4
) (
  input  logic            clk,
  input  logic [NB-1:0]   we_mask,
  input  logic [AW-1:0]   waddr,
  input  logic [NB*8-1:0] wdata,
  input  logic [AW-1:0]   raddr,
  output logic [NB*8-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    logic [7:0] lane [DEPTH];
    always_ff @(posedge clk) begin
      if (we_mask[b]) lane[waddr] <= wdata[b*8 +: 8];
    end
    assign rdata[b*8 +: 8] = lane[raddr];
  end
endmodule

// File: rtl/psram_core.sv
module psram_core #(
  parameter int AW = 6,
  parameter int NB = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   addr_in,
  input  logic            proc_strb_n,
  input  logic            ctrl_strb_n,
  input  logic            burst_adv_n,
  input  logic            sel_a_n,
  input  logic            sel_b,
  input  logic            sel_c_n,
  input  logic            wr_all_n,
  input  logic            wr_byte_n,
  input  logic [NB-1:0]   byte_sel_n,
  input  logic            out_en_n,
  input  logic            seq_linear,
  input  logic [NB*8-1:0] dq_i,
  output logic [NB*8-1:0] dq_o,
  output logic            dq_oe
);
  import psram_pkg::*;
  localparam int DW = NB * 8;

  acc_e          acc;
  logic          load, step, sel_q;
  logic [NB-1:0] wmask;
  logic [AW-1:0] cur_addr, nxt_addr, acc_addr;
  logic [DW-1:0] rdata;

  logic          rd_pend_q, rd_pend_d;
  logic [AW-1:0] rd_addr_q, rd_addr_d;
  logic          wr_q, wr_d;
  logic          dvalid_q, dvalid_d;
  logic [DW-1:0] dout_q;

  psram_ctrl #(.NB(NB)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .proc_strb_n(proc_strb_n), .ctrl_strb_n(ctrl_strb_n), .burst_adv_n(burst_adv_n),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .byte_sel_n(byte_sel_n),
    .acc(acc), .load(load), .step(step), .wmask(wmask), .sel_q(sel_q)
  );

  psram_burst #(.AW(AW)) u_burst (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step), .lin_in(seq_linear),
    .addr_in(addr_in), .cur_addr(cur_addr), .nxt_addr(nxt_addr)
  );

  // a loading edge uses the pins; a continuation edge uses the counter
  assign acc_addr = load ? addr_in : (step ? nxt_addr : cur_addr);

  psram_array #(.AW(AW), .NB(NB)) u_array (
    .clk(clk), .we_mask(wmask), .waddr(acc_addr), .wdata(dq_i),
    .raddr(rd_addr_q), .rdata(rdata)
  );

  always_comb begin
    rd_pend_d = (acc == ACC_READ);
    rd_addr_d = acc_addr;
    wr_d      = (acc == ACC_WRITE);
    dvalid_d  = rd_pend_q && (acc != ACC_DESEL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_pend_q <= 1'b0;
      rd_addr_q <= '0;
      wr_q      <= 1'b0;
      dvalid_q  <= 1'b0;
    end else begin
      rd_pend_q <= rd_pend_d;
      rd_addr_q <= rd_addr_d;
      wr_q      <= wr_d;
      dvalid_q  <= dvalid_d;
    end
  end

  // output register, loaded only when a read is in flight
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         dout_q <= '0;
    else if (rd_pend_q) dout_q <= rdata;
  end

  assign dq_o  = dout_q;
  assign dq_oe = dvalid_q && !wr_q && !out_en_n;
endmodule

// File: rtl/psram_core_chk.sv
module psram_core_chk #(
  parameter int NB = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            proc_strb_n,
  input logic            ctrl_strb_n,
  input logic            sel_a_n,
  input logic            out_en_n,
  input logic            dq_oe,
  input psram_pkg::acc_e acc,
  input logic            load,
  input logic [NB-1:0]   wmask,
  input logic            sel_q
);
  import psram_pkg::*;

  p_oe_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_en_n |-> !dq_oe);

  p_wr_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc == ACC_WRITE) |=> !dq_oe);

  p_desel_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc == ACC_DESEL) |=> !dq_oe);

  p_reselect_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !sel_q) |=> !dq_oe);

  p_proc_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_a_n && ctrl_strb_n) |-> !load);

  p_proc_nowrite_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!proc_strb_n && !sel_a_n) |-> (wmask == '0));
endmodule

bind psram_core psram_core_chk #(.NB(NB)) u_chk (
  .clk(clk), .rst_n(rst_n), .proc_strb_n(proc_strb_n), .ctrl_strb_n(ctrl_strb_n),
  .sel_a_n(sel_a_n), .out_en_n(out_en_n), .dq_oe(dq_oe), .acc(acc),
  .load(load), .wmask(wmask), .sel_q(sel_q)
);

// File: tb/psram_core_bench.sv
module psram_core_bench;
  localparam int AW = 6;
  localparam int NB = 4;
  localparam int DW = NB * 8;

  logic clk = 1'b0;
  logic rst_n;
  logic [AW-1:0] addr_in;
  logic proc_strb_n, ctrl_strb_n, burst_adv_n;
  logic sel_a_n, sel_b, sel_c_n;
  logic wr_all_n, wr_byte_n;
  logic [NB-1:0] byte_sel_n;
  logic out_en_n, seq_linear;
  logic [DW-1:0] dq_i, dq_o;
  logic dq_oe;

  logic [DW-1:0] ref_mem [1 << AW];
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  psram_core #(.AW(AW), .NB(NB)) u_psram_core (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in),
    .proc_strb_n(proc_strb_n), .ctrl_strb_n(ctrl_strb_n), .burst_adv_n(burst_adv_n),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .byte_sel_n(byte_sel_n),
    .out_en_n(out_en_n), .seq_linear(seq_linear),
    .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe)
  );

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle_in();
    proc_strb_n = 1'b1; ctrl_strb_n = 1'b1; burst_adv_n = 1'b1;
    sel_a_n = 1'b0; sel_b = 1'b1; sel_c_n = 1'b0;
    wr_all_n = 1'b1; wr_byte_n = 1'b1; byte_sel_n = '1;
  endtask

  task automatic deselect();
    idle_in();
    ctrl_strb_n = 1'b0; sel_b = 1'b0;
    tick();
    idle_in();
  endtask

  task automatic ctrl_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                            input logic gw_n, input logic bwe_n, input logic [NB-1:0] bs_n);
    idle_in();
    ctrl_strb_n = 1'b0; addr_in = a; dq_i = d;
    wr_all_n = gw_n; wr_byte_n = bwe_n; byte_sel_n = bs_n;
    tick();
    for (int b = 0; b < NB; b++)
      if (!gw_n || (!bwe_n && !bs_n[b])) ref_mem[a][b*8 +: 8] = d[b*8 +: 8];
    idle_in();
  endtask

  task automatic read_chk(input logic [AW-1:0] a, input string req);
    deselect();
    ctrl_strb_n = 1'b0; addr_in = a;
    tick();
    idle_in();
    tick();
    chk(dq_oe === 1'b1 && dq_o === ref_mem[a], req, dq_o, ref_mem[a]);
    deselect();
  endtask

  task automatic t_reset();
    chk(dq_oe === 1'b0, "R11 reset state oe", {31'd0, dq_oe}, '0);
  endtask

  task automatic t_single_read();
    ctrl_write(6'd5, 32'hA5A5_0005, 1'b0, 1'b1, '1);
    deselect();
    ctrl_strb_n = 1'b0; addr_in = 6'd5;
    tick();
    idle_in();
    chk(dq_oe === 1'b0, "R4 first cycle quiet", {31'd0, dq_oe}, '0);
    tick();
    chk(dq_oe === 1'b1 && dq_o === ref_mem[5], "R1 read latency", dq_o, ref_mem[5]);
    deselect();
  endtask

  task automatic t_back_to_back();
    for (int i = 0; i < 3; i++) ctrl_write(6'(20 + i), 32'h2000_0000 + 32'(i * 7 + 1), 1'b0, 1'b1, '1);
    deselect();
    for (int i = 0; i < 4; i++) begin
      idle_in();
      if (i < 3) begin ctrl_strb_n = 1'b0; addr_in = 6'(20 + i); end
      tick();
      if (i > 0)
        chk(dq_oe === 1'b1 && dq_o === ref_mem[20 + i - 1], "R2 back-to-back order",
            dq_o, ref_mem[20 + i - 1]);
    end
    deselect();
  endtask

  task automatic t_proc_gated();
    deselect();
    ctrl_strb_n = 1'b0; addr_in = 6'd20;
    tick();
    idle_in();
    proc_strb_n = 1'b0; sel_a_n = 1'b1; addr_in = 6'd21;
    tick();
    idle_in();
    tick();
    chk(dq_oe === 1'b1 && dq_o === ref_mem[20], "R3 proc strobe ignored", dq_o, ref_mem[20]);
    deselect();
  endtask

  task automatic t_deselect();
    deselect();
    ctrl_strb_n = 1'b0; addr_in = 6'd5;
    tick();
    idle_in();
    ctrl_strb_n = 1'b0; sel_c_n = 1'b1;
    tick();
    idle_in();
    chk(dq_oe === 1'b0, "R5 deselect drops output", {31'd0, dq_oe}, '0);
    tick();
    chk(dq_oe === 1'b0, "R5 stays deselected", {31'd0, dq_oe}, '0);
  endtask

  task automatic t_proc_write();
    ctrl_write(6'd30, 32'h1111_0000, 1'b0, 1'b1, '1);
    deselect();
    proc_strb_n = 1'b0; addr_in = 6'd30; wr_all_n = 1'b0; dq_i = 32'hDEAD_BEEF;
    tick();
    deselect();
    read_chk(6'd30, "R6 loading edge ignores write");
    proc_strb_n = 1'b0; addr_in = 6'd30; burst_adv_n = 1'b0; dq_i = 32'h0;
    tick();
    idle_in();
    wr_all_n = 1'b0; dq_i = 32'hCAFE_0030; addr_in = 6'd31;
    tick();
    ref_mem[30] = 32'hCAFE_0030;
    deselect();
    read_chk(6'd30, "R6 second edge writes");
  endtask

  task automatic t_ctrl_write();
    deselect();
    ctrl_write(6'd40, 32'h4040_4040, 1'b0, 1'b1, '1);
    ctrl_strb_n = 1'b0; addr_in = 6'd40;
    tick();
    idle_in();
    tick();
    chk(dq_oe === 1'b1 && dq_o === 32'h4040_4040, "R7 single-edge write", dq_o, 32'h4040_4040);
    deselect();
  endtask

  task automatic t_all_bytes();
    ctrl_write(6'd41, 32'h0, 1'b0, 1'b1, '1);
    ctrl_write(6'd41, 32'h1234_5678, 1'b0, 1'b0, 4'b1111);
    deselect();
    chk(ref_mem[41] === 32'h1234_5678, "R8 bench model", ref_mem[41], 32'h1234_5678);
    read_chk(6'd41, "R8 all-bytes override");
  endtask

  task automatic t_bytes();
    ctrl_write(6'd42, 32'hFFFF_FFFF, 1'b0, 1'b1, '1);
    ctrl_write(6'd42, 32'h1122_3344, 1'b1, 1'b0, 4'b1010);
    ctrl_write(6'd42, 32'h0, 1'b1, 1'b0, 4'b1111);
    deselect();
    chk(ref_mem[42] === 32'hFF22_FF44, "R9 bench model", ref_mem[42], 32'hFF22_FF44);
    read_chk(6'd42, "R9 byte merge");
  endtask

  task automatic t_write_quiet();
    deselect();
    ctrl_strb_n = 1'b0; addr_in = 6'd5;
    tick();
    ctrl_write(6'd43, 32'h4343_4343, 1'b0, 1'b1, '1);
    chk(dq_oe === 1'b0, "R10 write forces bus off", {31'd0, dq_oe}, '0);
    deselect();
  endtask

  task automatic t_out_enable();
    deselect();
    ctrl_strb_n = 1'b0; addr_in = 6'd5;
    tick();
    idle_in();
    tick();
    out_en_n = 1'b1;
    #1;
    chk(dq_oe === 1'b0, "R11 oe high forces off", {31'd0, dq_oe}, '0);
    out_en_n = 1'b0;
    #1;
    chk(dq_oe === 1'b1 && dq_o === ref_mem[5], "R11 oe low drives", dq_o, ref_mem[5]);
    deselect();
  endtask

  task automatic t_burst(input logic lin, input string req);
    logic [AW-1:0] exp_a;
    for (int i = 0; i < 4; i++) ctrl_write(6'(8 + i), 32'hB000_0000 + 32'(i * 3 + 2), 1'b0, 1'b1, '1);
    deselect();
    seq_linear = lin;
    ctrl_strb_n = 1'b0; addr_in = 6'd9;
    tick();
    idle_in();
    for (int k = 0; k < 4; k++) begin
      burst_adv_n = (k == 3);
      tick();
      exp_a = {4'b0010, lin ? 2'(2'b01 + 2'(k)) : 2'(2'b01 ^ 2'(k))};
      chk(dq_oe === 1'b1 && dq_o === ref_mem[exp_a], req, dq_o, ref_mem[exp_a]);
    end
    tick();
    chk(dq_oe === 1'b1 && dq_o === ref_mem[exp_a], "R14 suspend repeats", dq_o, ref_mem[exp_a]);
    deselect();
    seq_linear = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    idle_in();
    addr_in = '0; dq_i = '0; out_en_n = 1'b0; seq_linear = 1'b1;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_single_read();
    t_back_to_back();
    t_proc_gated();
    t_deselect();
    t_proc_write();
    t_ctrl_write();
    t_all_bytes();
    t_bytes();
    t_write_quiet();
    t_out_enable();
    t_burst(1'b1, "R12 linear burst");
    t_burst(1'b0, "R13 interleaved burst");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule